// File: doc/BRIEF.md
# Speculative Task Sequencer with Ordered Commit

This block hands out coarse program tasks to a ring of parallel execution units and retires those tasks strictly in the order it handed them out. A front end offers the next task together with the start address its task-level predictor chose. The sequencer gives that task to the unit at the young end of the ring. Task boundaries are the only unit of speculation here, and the sequencer never looks inside a task.

Each unit reports with a single-cycle pulse when its task has finished. A resolution port says, per unit, whether the prediction that started the task was right. A task is retired when it is the oldest live task, has finished, and its incoming prediction has been confirmed. Retiring means a commit strobe names the unit so that its buffered register and memory changes may be written back. When a prediction is reported wrong, that task and every task younger than it are discarded together. The unit slots they held return to the free pool. One cycle later the block presents the corrected successor address so that fetch can resume behind the last task that was still on the right path.

Top module: `tseq_ctrl`

## Requirements
- R1: After reset no unit holds a task, no commit, squash or restart is signalled, and the first accepted request is given to unit 0.
- R2: While `req_valid_i` is high, fewer than N_UNITS tasks are live and no squash occurs in the same cycle, `assign_valid_o` is high in that cycle. `assign_addr_o` equals `req_addr_i`, and `assign_unit_o` is the unit after the most recently assigned one, counted modulo N_UNITS, or the restart unit after a squash.
- R3: While all N_UNITS units hold live tasks, `assign_valid_o` stays low whatever the request input does.
- R4: `commit_valid_o` is high in a cycle only if the oldest live task has had a done pulse and a correct resolution (`resolve_ok_i` = 1) in earlier cycles. `commit_unit_o` then names that oldest unit, and at most one task commits per cycle.
- R5: A younger task that has finished and been confirmed does not commit while any older task is still live.
- R6: A resolution with `resolve_ok_i` = 0 naming a live unit raises `squash_o`, one bit per unit, in that same cycle for that unit and every younger live unit. The next assignment then goes to the mispredicted unit.
- R7: One cycle after a squash, `restart_valid_o` is high for exactly one cycle and `restart_addr_o` carries the `resolve_addr_i` value given with the misprediction.
- R8: A squash that covers the oldest task suppresses its commit. If the squash starts at a younger task, the oldest task still commits in that cycle when it is eligible.
- R9: A done pulse or a resolution naming a unit with no live task has no effect. A task later assigned to that unit needs a fresh done pulse before it can commit, and a wrong resolution for a free unit produces no squash.
- R10: A request in a squash cycle is not accepted: `assign_valid_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A next task is offered |
| req_addr_i | input | ADDR_W | Predicted start address of the offered task |
| assign_valid_o | output | 1 | The offered task is accepted this cycle |
| assign_unit_o | output | IDX_W | Unit receiving the task |
| assign_addr_o | output | ADDR_W | Start address passed to that unit |
| done_i | input | N_UNITS | Per-unit task-finished pulses |
| resolve_valid_i | input | 1 | A resolution report is present |
| resolve_unit_i | input | IDX_W | Unit whose incoming prediction is resolved |
| resolve_ok_i | input | 1 | 1 = prediction correct, 0 = mispredicted |
| resolve_addr_i | input | ADDR_W | Corrected successor address on a misprediction |
| commit_valid_o | output | 1 | The oldest task retires this cycle |
| commit_unit_o | output | IDX_W | Unit whose state may be written back |
| squash_o | output | N_UNITS | Per-unit discard strobes |
| restart_valid_o | output | 1 | Fetch must resume at the corrected address |
| restart_addr_o | output | ADDR_W | Corrected successor address |

## Verification
A retirement of the oldest task and a misprediction squash can land in the same cycle, and the outcome depends on where the squash begins. The bench sets up the oldest task as done and confirmed, then in one cycle reports a misprediction on a younger unit, where the commit must still go out. It also reports one on the oldest unit itself, where the commit must vanish and every live unit be discarded. A queue-based reference model decides the expected commit, squash mask and next assignment unit every cycle, including a long stretch of random requests, done pulses and resolutions that produce many such collisions.

// File: rtl/tseq_pkg.sv
package tseq_pkg;

    // Steps forward from one ring position to another, modulo n.
    function automatic int ring_dist(int from_i, int to_i, int n);
        if (to_i >= from_i) begin
            return to_i - from_i;
        end
        return to_i + n - from_i;
    endfunction

    function automatic int ring_next(int idx, int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/tseq_onehot.sv
module tseq_onehot #(
    parameter int N_UNITS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [IDX_W-1:0]   idx_i,
    output logic [N_UNITS-1:0] oh_o
);
    for (genvar k = 0; k < N_UNITS; k++) begin : g_bit
        assign oh_o[k] = (idx_i == IDX_W'(k));
    end
endmodule

// File: rtl/tseq_range_mask.sv
module tseq_range_mask
    import tseq_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int IDX_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic [IDX_W-1:0]   base_i,
    input  logic [CNT_W-1:0]   len_i,
    output logic [N_UNITS-1:0] mask_o
);
    // Slot k is covered when it lies fewer than len_i steps past base_i.
    for (genvar k = 0; k < N_UNITS; k++) begin : g_slot
        int offset;
        always_comb begin
            offset    = ring_dist(int'(base_i), k, N_UNITS);
            mask_o[k] = (offset < int'(len_i));
        end
    end
endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
    import tseq_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int CNT_W  = $clog2(N_UNITS + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output logic               assign_valid_o,
    output logic [IDX_W-1:0]   assign_unit_o,
    output logic [ADDR_W-1:0]  assign_addr_o,
    input  logic [N_UNITS-1:0] done_i,
    input  logic               resolve_valid_i,
    input  logic [IDX_W-1:0]   resolve_unit_i,
    input  logic               resolve_ok_i,
    input  logic [ADDR_W-1:0]  resolve_addr_i,
    output logic               commit_valid_o,
    output logic [IDX_W-1:0]   commit_unit_o,
    output logic [N_UNITS-1:0] squash_o,
    output logic               restart_valid_o,
    output logic [ADDR_W-1:0]  restart_addr_o
);

    typedef struct packed {
        logic [N_UNITS-1:0] live;
        logic [N_UNITS-1:0] fin;
        logic [N_UNITS-1:0] conf;
        logic [IDX_W-1:0]   head;
        logic [IDX_W-1:0]   tail;
        logic [CNT_W-1:0]   count;
        logic               rs_flag;
        logic [ADDR_W-1:0]  rs_addr;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic               full;
    logic               squash_hit;
    logic               commit_fire;
    logic               assign_fire;
    int                 head_age;
    logic [CNT_W-1:0]   squash_len;
    logic [N_UNITS-1:0] squash_mask;
    logic [N_UNITS-1:0] head_oh;
    logic [N_UNITS-1:0] tail_oh;
    logic [N_UNITS-1:0] clear_mask;

    // Signals observed by the bound checker.
    logic [N_UNITS-1:0] slot_valid;
    logic [CNT_W-1:0]   live_cnt;
    assign slot_valid = state_q.live;
    assign live_cnt   = state_q.count;

    tseq_onehot #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_head_dec (
        .idx_i (state_q.head),
        .oh_o  (head_oh)
    );

    tseq_onehot #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_tail_dec (
        .idx_i (state_q.tail),
        .oh_o  (tail_oh)
    );

    tseq_range_mask #(.N_UNITS(N_UNITS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_squash_rng (
        .base_i (resolve_unit_i),
        .len_i  (squash_len),
        .mask_o (squash_mask)
    );

    // Squash detection and the length of the discarded range.
    always_comb begin
        squash_hit = resolve_valid_i && !resolve_ok_i && state_q.live[resolve_unit_i];
        head_age   = ring_dist(int'(state_q.head), int'(resolve_unit_i), N_UNITS);
        squash_len = squash_hit ? CNT_W'(int'(state_q.count) - head_age) : '0;
    end

    // Retirement gating, assignment gating and next state.
    always_comb begin
        full        = (state_q.count == CNT_W'(N_UNITS));
        commit_fire = state_q.live[state_q.head] && state_q.fin[state_q.head]
                      && state_q.conf[state_q.head]
                      && !(squash_hit && (resolve_unit_i == state_q.head));
        assign_fire = req_valid_i && !full && !squash_hit;
        clear_mask  = squash_mask | (commit_fire ? head_oh : '0);

        state_d      = state_q;
        state_d.fin  = state_q.fin | (done_i & state_q.live);
        if (resolve_valid_i && resolve_ok_i && state_q.live[resolve_unit_i]) begin
            state_d.conf[resolve_unit_i] = 1'b1;
        end

        state_d.live = state_d.live & ~clear_mask;
        state_d.fin  = state_d.fin  & ~clear_mask;
        state_d.conf = state_d.conf & ~clear_mask;

        if (assign_fire) begin
            state_d.live = state_d.live |  tail_oh;
            state_d.fin  = state_d.fin  & ~tail_oh;
            state_d.conf = state_d.conf & ~tail_oh;
        end

        if (commit_fire) begin
            state_d.head = IDX_W'(ring_next(int'(state_q.head), N_UNITS));
        end

        if (squash_hit) begin
            state_d.tail  = resolve_unit_i;
            state_d.count = CNT_W'(head_age - (commit_fire ? 1 : 0));
        end else begin
            if (assign_fire) begin
                state_d.tail = IDX_W'(ring_next(int'(state_q.tail), N_UNITS));
            end
            state_d.count = CNT_W'(int'(state_q.count) + (assign_fire ? 1 : 0)
                                   - (commit_fire ? 1 : 0));
        end

        state_d.rs_flag = squash_hit;
        if (squash_hit) begin
            state_d.rs_addr = resolve_addr_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign assign_valid_o  = assign_fire;
    assign assign_unit_o   = state_q.tail;
    assign assign_addr_o   = req_addr_i;
    assign commit_valid_o  = commit_fire;
    assign commit_unit_o   = state_q.head;
    assign squash_o        = squash_mask;
    assign restart_valid_o = state_q.rs_flag;
    assign restart_addr_o  = state_q.rs_addr;

endmodule

// File: rtl/tseq_ctrl_chk.sv
module tseq_ctrl_chk #(
    parameter int N_UNITS = 4,
    localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int CNT_W  = $clog2(N_UNITS + 1)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               assign_valid_o,
    input logic [IDX_W-1:0]   assign_unit_o,
    input logic               commit_valid_o,
    input logic [IDX_W-1:0]   commit_unit_o,
    input logic [N_UNITS-1:0] squash_o,
    input logic               restart_valid_o,
    input logic [IDX_W-1:0]   resolve_unit_i,
    input logic [N_UNITS-1:0] slot_valid,
    input logic [CNT_W-1:0]   live_cnt
);

    assert_assign_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        assign_valid_o |-> !slot_valid[assign_unit_o]);

    assert_stall_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (live_cnt == CNT_W'(N_UNITS)) |-> !assign_valid_o);

    assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_cnt <= CNT_W'(N_UNITS));

    assert_commit_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_valid_o |-> slot_valid[commit_unit_o]);

    assert_squash_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|squash_o) |-> squash_o[resolve_unit_i]);

    assert_squash_live_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (squash_o & ~slot_valid) == '0);

    assert_restart_after_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|squash_o) |=> restart_valid_o);

    assert_restart_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_valid_o |-> $past(|squash_o));

    assert_commit_unsquashed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_valid_o |-> !squash_o[commit_unit_o]);

    assert_squash_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|squash_o) |-> !assign_valid_o);

endmodule

bind tseq_ctrl tseq_ctrl_chk #(.N_UNITS(N_UNITS)) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .assign_valid_o  (assign_valid_o),
    .assign_unit_o   (assign_unit_o),
    .commit_valid_o  (commit_valid_o),
    .commit_unit_o   (commit_unit_o),
    .squash_o        (squash_o),
    .restart_valid_o (restart_valid_o),
    .resolve_unit_i  (resolve_unit_i),
    .slot_valid      (slot_valid),
    .live_cnt        (live_cnt)
);

// File: tb/tseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module tseq_ctrl_tb_top;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam int IW = 2;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic          assign_valid_o;
    logic [IW-1:0] assign_unit_o;
    logic [AW-1:0] assign_addr_o;
    logic [N-1:0]  done_i = '0;
    logic          resolve_valid_i = 1'b0;
    logic [IW-1:0] resolve_unit_i = '0;
    logic          resolve_ok_i = 1'b0;
    logic [AW-1:0] resolve_addr_i = '0;
    logic          commit_valid_o;
    logic [IW-1:0] commit_unit_o;
    logic [N-1:0]  squash_o;
    logic          restart_valid_o;
    logic [AW-1:0] restart_addr_o;

    always #2.5 clk_i = ~clk_i;

    tseq_ctrl #(.N_UNITS(N), .ADDR_W(AW)) dut_i (
        .clk_i, .rst_ni, .req_valid_i, .req_addr_i,
        .assign_valid_o, .assign_unit_o, .assign_addr_o,
        .done_i, .resolve_valid_i, .resolve_unit_i, .resolve_ok_i, .resolve_addr_i,
        .commit_valid_o, .commit_unit_o, .squash_o,
        .restart_valid_o, .restart_addr_o
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model: live tasks oldest first.
    int            ord[$];
    bit            m_done[N];
    bit            m_ok[N];
    int            nxt_unit = 0;
    bit            exp_rst = 0;
    logic [AW-1:0] exp_radr = '0;

    task automatic check(string tag, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit rq, logic [AW-1:0] ra, logic [N-1:0] dn,
                        bit rv, int ru, bit rok, logic [AW-1:0] radr);
        int pos;
        bit sq, cm, as;
        logic [N-1:0] mask;
        req_valid_i     = rq;
        req_addr_i      = ra;
        done_i          = dn;
        resolve_valid_i = rv;
        resolve_unit_i  = IW'(ru);
        resolve_ok_i    = rok;
        resolve_addr_i  = radr;
        #1;
        pos = -1;
        foreach (ord[i]) if (ord[i] == ru) pos = i;
        sq   = rv && !rok && (pos >= 0);
        mask = '0;
        if (sq) for (int i = pos; i < ord.size(); i++) mask[ord[i]] = 1'b1;
        cm = (ord.size() > 0) && m_done[ord[0]] && m_ok[ord[0]] && !(sq && pos == 0);
        as = rq && (ord.size() < N) && !sq;

        check("R2 R3 R10", "assign_valid", assign_valid_o, as);
        if (as) begin
            check("R1 R2 R6", "assign_unit", assign_unit_o, nxt_unit);
            check("R2", "assign_addr", assign_addr_o, ra);
        end
        check("R4 R5 R8 R9", "commit_valid", commit_valid_o, cm);
        if (cm) check("R4", "commit_unit", commit_unit_o, ord[0]);
        check("R6 R8 R9", "squash", squash_o, mask);
        check("R7", "restart_valid", restart_valid_o, exp_rst);
        if (exp_rst) check("R7", "restart_addr", restart_addr_o, exp_radr);

        @(posedge clk_i);
        foreach (ord[i]) begin
            if (dn[ord[i]]) m_done[ord[i]] = 1;
        end
        if (rv && rok && pos >= 0) m_ok[ru] = 1;
        if (sq) begin
            while (ord.size() > pos) begin
                int u = ord.pop_back();
                m_done[u] = 0; m_ok[u] = 0;
            end
            nxt_unit = ru;
        end
        if (cm) begin
            int u = ord.pop_front();
            m_done[u] = 0; m_ok[u] = 0;
        end
        if (as) begin
            ord.push_back(nxt_unit);
            m_done[nxt_unit] = 0; m_ok[nxt_unit] = 0;
            nxt_unit = (nxt_unit + 1) % N;
        end
        exp_rst = sq;
        if (sq) exp_radr = radr;
        @(negedge clk_i);
    endtask

    task automatic idle();
        step(0, '0, '0, 0, 0, 0, '0);
    endtask

    task automatic req(logic [AW-1:0] a);
        step(1, a, '0, 0, 0, 0, '0);
    endtask

    task automatic fin(int u);
        step(0, '0, N'(1 << u), 0, 0, 0, '0);
    endtask

    task automatic good(int u);
        step(0, '0, '0, 1, u, 1, '0);
    endtask

    task automatic bad(int u, logic [AW-1:0] a, bit rq);
        step(rq, 32'h9999_0000, '0, 1, u, 0, a);
    endtask

    initial begin
        repeat (1000000) @(posedge clk_i);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1: empty after reset, first request to unit 0.
        idle();
        req(32'h1000);
        // R2, R3: fill the ring, then a stalled request.
        req(32'h1100); req(32'h1200); req(32'h1300);
        req(32'h1400); req(32'h1400);
        // R5: a younger task finished and confirmed must wait.
        fin(2); good(2); idle();
        // R4: oldest finishes and is confirmed, commit with request pending.
        fin(0); good(0);
        req(32'h1400); req(32'h1400); req(32'h1400);
        // R6, R7: mispredict a middle task, then restart and reuse its unit.
        bad(3, 32'hA000_0040, 0);
        idle();
        req(32'h2000);
        // R8: oldest eligible, squash starts younger in the same cycle.
        fin(1); good(1);
        bad(2, 32'hB000_0080, 0);
        idle();
        req(32'h2100); req(32'h2200);
        // R8: squash that covers the eligible oldest task suppresses commit.
        fin(2); good(2);
        bad(2, 32'hC000_00C0, 1);   // R10: request in squash cycle refused
        idle();
        // R9: pulses and resolutions for free units are ignored.
        step(0, '0, '1, 0, 0, 0, '0);
        good(2);
        bad(3, 32'hDEAD_0000, 0);
        req(32'h3000);
        good(2); idle(); idle();
        fin(2); idle();
        // Random mix, including many collisions.
        for (int i = 0; i < 600; i++) begin
            bit rq, rv, rok;
            int ru;
            logic [N-1:0] dn;
            rq  = ($urandom % 3) != 0;
            dn  = N'($urandom);
            rv  = ($urandom % 2) == 1;
            ru  = $urandom % N;
            rok = ($urandom % 5) != 0;
            step(rq, $urandom, dn, rv, ru, rok, $urandom);
        end
        idle(); idle();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule